// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a combinational two-level logic array. It has 16 input lines, 48 product terms and 8 output functions. Each product term is an AND of literals. For every input, a term can use the true form, use the complemented form, or leave the input out.

Each output ORs together any subset of the 48 terms. A per-output inversion bit then selects true or inverted polarity. A chip-enable input gates the outputs. A parameter sets the output drive mode:

- **Three-state mode**: the block exposes the output levels together with an output-enable vector.
- **Open-collector mode**: a disabled block reads as all ones. An enabled block reports which lines it pulls low.

The configuration that fuses would normally hold sits in registers. A synchronous word-write port loads them. The word address selects one of three targets: a product term, the OR mask of one output, or the polarity word. A write lands on a rising clock edge and is visible at the outputs straight after that edge. The evaluation path from the input lines and chip enable to the outputs is purely combinational.

Top module: `sop_array`

## Requirements
- R1: A term word holds one 2-bit selector per input, at bits [2i+1:2i] for input i. The selector codes are:
  - 2'b01: the term needs input i high.
  - 2'b10: the term needs input i low.
  - 2'b11: input i is left out of the term.
  - 2'b00: the term is forced to 0.
- R2: A term whose selectors are all 2'b11 evaluates to 1 for every input pattern.
- R3: The OR value of output o is the OR of every term t whose bit t is set in the mask word of o. An empty mask gives 0.
- R4: Bit o of the polarity word inverts output o after the OR stage. When the bit is 0, the OR value passes through unchanged.
- R5: The write address map is as follows:
  - Addresses 0..47 load term words from data bits [31:0].
  - Addresses 48..55 load the mask of output (address-48) from data bits [47:0].
  - Address 56 loads the polarity word from data bits [7:0].
  - Addresses 57..63, and any cycle with the write strobe low, change nothing.
- R6: A write strobed at a rising edge changes the outputs straight after that edge. Changes on the input lines or on chip enable reach the outputs in the same cycle, with no clock edge needed.
- R7: After synchronous active-low reset, every selector is 2'b00, every mask is empty and the polarity word is 0. The enabled outputs therefore read 0.
- R8: In three-state mode, `dout` carries the array value. `dout_oe` is all ones while chip enable is high and all zeros while it is low.
- R9: In open-collector mode, with chip enable low, `dout` is all ones and `dout_oe` is all zeros. With chip enable high, `dout` carries the array value and `dout_oe` is its bitwise complement, meaning the lines actively pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 48 | Configuration write data |
| din | input | 16 | Array input lines |
| chip_en | input | 1 | Output enable (active high) |
| dout | output | 8 | Output levels |
| dout_oe | output | 8 | Per-line drive enable |

## Verification
A configuration write takes effect one edge after it is strobed. Input and chip-enable changes appear at the outputs within the same cycle, through combinational logic only. The driver therefore applies every stimulus 2 ns after a rising edge. It pushes the expected output words of both drive modes into a queue at that moment. The monitor pops and compares them at the following falling edge, after the write edge for configuration and after settling for input changes.

// File: rtl/sop_array_pkg.sv
// Package: shared encodings for the sum-of-products array.
// Assumes: selector bit 0 lets a high input pass, bit 1 lets a low input pass.
package sop_array_pkg;

    typedef enum logic [1:0] {
        LIT_NONE = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_SKIP = 2'b11
    } lit_sel_e;

    typedef enum logic {
        DRV_TRISTATE       = 1'b0,
        DRV_OPEN_COLLECTOR = 1'b1
    } drive_mode_e;

    // One literal of a term: passes when the input level is allowed by the selector.
    function automatic logic lit_pass(input logic [1:0] sel, input logic x);
        return (x & sel[0]) | (~x & sel[1]);
    endfunction

endpackage

// File: rtl/sop_and_plane.sv
// Module: AND plane. Holds one selector word per product term and evaluates
// every term from the input lines.
// Assumes: wr_en is already qualified by the address decoder.
module sop_and_plane
    import sop_array_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2*N_IN-1:0] wr_word,
    input  logic [N_IN-1:0]   din,
    output logic [N_TERM-1:0] terms
);

    localparam int TERM_W = 2 * N_IN;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [TERM_W-1:0] sel_q;
        logic              hit;

        // Selector storage for term t; reset forces every literal to 2'b00.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(t))) begin
                sel_q <= wr_word;
            end
        end

        // Product of all literals of term t.
        always_comb begin
            hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                hit = hit & lit_pass(sel_q[2*i +: 2], din[i]);
            end
        end

        assign terms[t] = hit;
    end

endmodule

// File: rtl/sop_or_plane.sv
// Module: OR plane. Holds one term mask per output and ORs the selected terms.
// Assumes: wr_en is already qualified; wr_idx is relative to the first mask.
module sop_or_plane #(
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [N_TERM-1:0] wr_mask,
    input  logic [N_TERM-1:0] terms,
    output logic [N_OUT-1:0]  sums
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] mask_q;

        // Mask storage for output o; reset leaves it unconnected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(o))) begin
                mask_q <= wr_mask;
            end
        end

        assign sums[o] = |(terms & mask_q);
    end

endmodule

// File: rtl/sop_out_stage.sv
// Module: polarity register, inversion and output drive for the chosen mode.
// Assumes: DRIVE_MODE is fixed at elaboration.
module sop_out_stage
    import sop_array_pkg::*;
#(
    parameter int          N_OUT      = 8,
    parameter drive_mode_e DRIVE_MODE = DRV_TRISTATE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pol_we,
    input  logic [N_OUT-1:0] pol_word,
    input  logic [N_OUT-1:0] sums,
    input  logic             chip_en,
    output logic [N_OUT-1:0] dout,
    output logic [N_OUT-1:0] dout_oe
);

    logic [N_OUT-1:0] pol_q;
    logic [N_OUT-1:0] level;

    // Polarity storage; reset selects non-inverted outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
        end else if (pol_we) begin
            pol_q <= pol_word;
        end
    end

    assign level = sums ^ pol_q;

    if (DRIVE_MODE == DRV_TRISTATE) begin : g_tri
        assign dout    = level;
        assign dout_oe = {N_OUT{chip_en}};
    end else begin : g_oc
        assign dout    = chip_en ? level : {N_OUT{1'b1}};
        assign dout_oe = chip_en ? ~level : {N_OUT{1'b0}};
    end

endmodule

// File: rtl/sop_array.sv
// Module: top of the configurable sum-of-products array. Decodes the
// configuration address and connects the AND plane, OR plane and output stage.
// Assumes: DATA_W covers both a term word and a mask word.
module sop_array
    import sop_array_pkg::*;
#(
    parameter int          N_IN       = 16,
    parameter int          N_OUT      = 8,
    parameter int          N_TERM     = 48,
    parameter drive_mode_e DRIVE_MODE = DRV_TRISTATE,
    parameter int          ADDR_W     = $clog2(N_TERM + N_OUT + 1),
    parameter int          DATA_W     = (2 * N_IN > N_TERM) ? 2 * N_IN : N_TERM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   din,
    input  logic              chip_en,
    output logic [N_OUT-1:0]  dout,
    output logic [N_OUT-1:0]  dout_oe
);

    localparam int TERM_W = 2 * N_IN;
    localparam logic [ADDR_W-1:0] MASK_BASE = ADDR_W'(N_TERM);
    localparam logic [ADDR_W-1:0] POL_ADDR  = ADDR_W'(N_TERM + N_OUT);

    logic              term_we;
    logic              mask_we;
    logic              pol_we;
    logic [ADDR_W-1:0] mask_idx;
    logic [N_TERM-1:0] terms;
    logic [N_OUT-1:0]  sums;

    // Address decode: pick the storage group that a write targets.
    always_comb begin
        term_we  = cfg_we && (cfg_addr < MASK_BASE);
        mask_we  = cfg_we && (cfg_addr >= MASK_BASE) && (cfg_addr < POL_ADDR);
        pol_we   = cfg_we && (cfg_addr == POL_ADDR);
        mask_idx = cfg_addr - MASK_BASE;
    end

    sop_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .IDX_W  (ADDR_W)
    ) u_and (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (term_we),
        .wr_idx  (cfg_addr),
        .wr_word (cfg_wdata[TERM_W-1:0]),
        .din     (din),
        .terms   (terms)
    );

    sop_or_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .IDX_W  (ADDR_W)
    ) u_or (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_idx  (mask_idx),
        .wr_mask (cfg_wdata[N_TERM-1:0]),
        .terms   (terms),
        .sums    (sums)
    );

    sop_out_stage #(
        .N_OUT      (N_OUT),
        .DRIVE_MODE (DRIVE_MODE)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .pol_we   (pol_we),
        .pol_word (cfg_wdata[N_OUT-1:0]),
        .sums     (sums),
        .chip_en  (chip_en),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

endmodule

// File: rtl/sop_array_chk.sv
// Module: property checker for sop_array, attached by bind.
// Assumes: it only observes the top-level ports.
module sop_array_chk
    import sop_array_pkg::*;
#(
    parameter int          N_IN       = 16,
    parameter int          N_OUT      = 8,
    parameter drive_mode_e DRIVE_MODE = DRV_TRISTATE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [N_IN-1:0]  din,
    input logic             chip_en,
    input logic [N_OUT-1:0] dout,
    input logic [N_OUT-1:0] dout_oe
);

    // R7: leaving reset with the block enabled, every output reads 0.
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && chip_en) |-> (dout == '0));

    // R5: with no write and steady inputs, the outputs hold.
    p_hold_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> (!($stable(din) && $stable(chip_en)) || $stable(dout)));

    if (DRIVE_MODE == DRV_TRISTATE) begin : g_tri
        // R8: a disabled block drives no line.
        p_tri_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !chip_en |-> (dout_oe == '0));
        // R8: an enabled block drives every line.
        p_tri_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
            chip_en |-> ($countones(dout_oe) == N_OUT));
    end else begin : g_oc
        // R9: a disabled block floats high.
        p_oc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !chip_en |-> ((dout == '1) && (dout_oe == '0)));
        // R9: an enabled block pulls down exactly the low lines.
        p_oc_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
            chip_en |-> (((dout & dout_oe) == '0) && ((dout | dout_oe) == '1)));
    end

endmodule

bind sop_array sop_array_chk #(
    .N_IN       (N_IN),
    .N_OUT      (N_OUT),
    .DRIVE_MODE (DRIVE_MODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .din     (din),
    .chip_en (chip_en),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/sop_array_tb.sv
// Bench: scoreboard for both drive modes of sop_array.
module sop_array_tb;
    import sop_array_pkg::*;

    logic        clk     = 1'b0;
    logic        rst_n   = 1'b0;
    logic        cfg_we  = 1'b0;
    logic [5:0]  cfg_addr  = '0;
    logic [47:0] cfg_wdata = '0;
    logic [15:0] din     = '0;
    logic        chip_en = 1'b1;
    logic [7:0]  ts_dout, ts_oe, oc_dout, oc_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] ts_d;
        logic [7:0] ts_oe;
        logic [7:0] oc_d;
        logic [7:0] oc_oe;
    } exp_t;
    exp_t sbq[$];

    logic [31:0] m_term [48];
    logic [47:0] m_mask [8];
    logic [7:0]  m_pol;

    always #5 clk = ~clk;

    sop_array u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .din(din), .chip_en(chip_en),
        .dout(ts_dout), .dout_oe(ts_oe)
    );

    sop_array #(.DRIVE_MODE(DRV_OPEN_COLLECTOR)) u_dut_oc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .din(din), .chip_en(chip_en),
        .dout(oc_dout), .dout_oe(oc_oe)
    );

    // Reference array value from R1..R4.
    function automatic logic [7:0] model_level(input logic [15:0] x);
        logic [47:0] tv;
        logic [7:0]  lv;
        for (int t = 0; t < 48; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < 16; i++) begin
                case (m_term[t][2*i +: 2])
                    2'b00:   tv[t] = 1'b0;
                    2'b01:   tv[t] = tv[t] & x[i];
                    2'b10:   tv[t] = tv[t] & ~x[i];
                    default: ;
                endcase
            end
        end
        for (int o = 0; o < 8; o++) lv[o] = |(tv & m_mask[o]);
        return lv ^ m_pol;
    endfunction

    // Driver side: push the expected items for the present stimulus.
    task automatic expect_now(input string tag);
        exp_t e;
        logic [7:0] lv;
        lv = model_level(din);
        e.tag   = tag;
        e.ts_d  = lv;
        e.ts_oe = chip_en ? 8'hFF : 8'h00;
        e.oc_d  = chip_en ? lv : 8'hFF;
        e.oc_oe = chip_en ? ~lv : 8'h00;
        sbq.push_back(e);
    endtask

    // One configuration cycle; the model decodes the address per R5.
    task automatic cfg_cycle(input bit we, input int addr, input logic [47:0] data,
                             input string tag);
        @(posedge clk); #2;
        cfg_we = we; cfg_addr = 6'(addr); cfg_wdata = data;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        if (we) begin
            if (addr < 48)      m_term[addr]    = data[31:0];
            else if (addr < 56) m_mask[addr-48] = data;
            else if (addr == 56) m_pol          = data[7:0];
        end
        expect_now(tag);
    endtask

    // Apply an input pattern and chip enable; results are due in the same cycle.
    task automatic apply(input logic [15:0] x, input bit en, input string tag);
        @(posedge clk); #2;
        din = x; chip_en = en;
        expect_now(tag);
    endtask

    // Monitor: compare queued items at the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            total++;
            if (ts_dout !== e.ts_d || ts_oe !== e.ts_oe ||
                oc_dout !== e.oc_d || oc_oe !== e.oc_oe) begin
                bad++;
                $display("FAIL %s: tri d=%h oe=%h oc d=%h oe=%h, expected tri d=%h oe=%h oc d=%h oe=%h",
                         e.tag, ts_dout, ts_oe, oc_dout, oc_oe,
                         e.ts_d, e.ts_oe, e.oc_d, e.oc_oe);
            end
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int t = 0; t < 48; t++) m_term[t] = '0;
        for (int o = 0; o < 8; o++)  m_mask[o] = '0;
        m_pol = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        din = 16'hA5C3;
        expect_now("R7 reset state enabled");
        apply(16'hFFFF, 1'b1, "R7 reset state all ones");
        apply(16'h1234, 1'b0, "R8 R9 disabled after reset");
        apply(16'h1234, 1'b1, "R8 R9 enabled after reset");

        // Terms (R1, R2) and R6 write visibility.
        cfg_cycle(1, 0,  48'h0000_FFFF_FFF9, "R1 R6 term0 written");
        cfg_cycle(1, 1,  48'h0000_FFFF_FFFF, "R2 term1 all skip");
        cfg_cycle(1, 2,  48'h0000_FFFF_FFFC, "R1 term2 forced zero");
        cfg_cycle(1, 3,  48'h0000_7FFF_FFFF, "R1 term3 in15 true");
        cfg_cycle(1, 47, 48'h0000_AFFF_FFFF, "R1 term47 in14 in15 low");
        // Masks (R3).
        cfg_cycle(1, 48, 48'h0000_0000_0001, "R3 R6 mask out0");
        cfg_cycle(1, 49, 48'h0000_0000_0002, "R2 R3 mask out1");
        cfg_cycle(1, 50, 48'h0000_0000_0004, "R1 R3 mask out2");
        cfg_cycle(1, 51, 48'h0000_0000_0009, "R3 mask out3");
        cfg_cycle(1, 53, 48'h0000_0000_0001, "R3 mask out5");
        cfg_cycle(1, 54, 48'h8000_0000_0002, "R3 mask out6");
        cfg_cycle(1, 55, 48'h8000_0000_0000, "R3 mask out7 top term");
        cfg_cycle(1, 56, 48'h0000_0000_0030, "R4 R6 polarity");
        // R5: ignored writes.
        cfg_cycle(0, 0,  48'h0,              "R5 strobe low ignored");
        cfg_cycle(1, 60, 48'hFFFF_FFFF_FFFF, "R5 out of map ignored");
        cfg_cycle(1, 57, 48'h0,              "R5 address 57 ignored");

        // Directed patterns (R1, R3, R4, R6).
        apply(16'h0000, 1'b1, "R1 R4 in all low");
        apply(16'h0001, 1'b1, "R1 term0 true");
        apply(16'h0003, 1'b1, "R1 term0 comp fails");
        apply(16'h8000, 1'b1, "R3 term3 only");
        apply(16'h4000, 1'b1, "R1 term47 fails");
        apply(16'hC001, 1'b1, "R3 term0 and term3");
        apply(16'hFFFF, 1'b1, "R6 all high");
        apply(16'h0001, 1'b0, "R8 R9 disabled");
        apply(16'h0001, 1'b1, "R8 R9 re-enabled");

        // Overwrite a term (R6) and the polarity (R4).
        cfg_cycle(1, 0,  48'h0000_FFFF_FFF6, "R6 term0 rewritten");
        cfg_cycle(1, 56, 48'h0000_0000_00C1, "R4 polarity rewritten");

        lfsr = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr, (k % 5) != 4, "R3 R8 R9 random pattern");
        end

        @(posedge clk); @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule